// File: doc/BRIEF.md
# Spindle Start-up and Head Calibration Sequencer

This block orders the bring-up of a fixed disk drive after power is applied. It times the active-low once-per-revolution index signal to measure spindle speed. It holds the local processor in reset until the spindle is past a low speed gate, and then waits for operating speed followed by a head-settling dwell. Once the heads have settled it steps through the calibration phases in a fixed order. First comes offset calibration of the two head-position signals. Then a counted burst of short seeks. Then a null-current dwell, in which the heads servo on one track while the holding current is learned. Last, the heads step back to track 0.

Each phase is started by a one-cycle strobe to an external engine. For the offset, seek and step phases the sequencer advances only when that engine raises its done input. The null-current phase is a timed dwell with no handshake. When the return to track 0 completes, the drive-ready and seek-complete flags rise. They stay high while the heads hold track 0, until the next power-on reset. A power-on reset at any time returns the block to its reset-hold state.

Top module: `spinup_sequencer`

## Requirements
- R1: While `por` is high, `cpu_rst_hold` is 1. While `por` is high, `drive_ready`, `seek_cmplt` and all four start strobes are 0.
- R2: The index period is the number of clock cycles between two consecutive 1-to-0 transitions of `index_n`. `cpu_rst_hold` falls only after a measured period shorter than `LOW_PERIOD_MAX`, within 8 cycles of the transition that ended that period. While periods are `LOW_PERIOD_MAX` or longer, `cpu_rst_hold` stays 1. Once it has fallen it stays 0 until `por`.
- R3: After the release, no phase starts while the measured period exceeds `OP_PERIOD_MAX`. The first period of at most `OP_PERIOD_MAX` starts a dwell of `SETTLE_CYCLES`. `cal_start` then pulses between `SETTLE_CYCLES` and `SETTLE_CYCLES`+8 cycles after the index transition that ended that period.
- R4: `cal_start` is a single-cycle strobe. No seek starts until `cal_done` has been seen high after it.
- R5: Exactly `SEEK_COUNT` `seek_start` strobes are issued, each after `seek_done` for the previous one. `seek_len` carries `SEEK_LEN` (the track distance, 5 by default) during each strobe.
- R6: After the last `seek_done`, `null_start` pulses once. `step_start` follows between `NULL_CYCLES` and `NULL_CYCLES`+3 cycles later, with no handshake in between.
- R7: `drive_ready` and `seek_cmplt` rise together in the cycle after `step_done` is first seen high following `step_start`, and `cpu_rst_hold` is 0 at that point.
- R8: Once raised, `drive_ready` and `seek_cmplt` stay 1 until `por`. Later done pulses and slower index periods start no phase and change no output.
- R9: `por` asserted at any point returns the block to reset hold. `cpu_rst_hold` goes to 1 and the flags go to 0 at once, and no strobe is issued while `por` stays high.
- R10: At most one start strobe is high in any cycle. Done inputs that arrive while no phase is waiting for them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, active high, asynchronous |
| index_n | input | 1 | Once-per-revolution index, active low |
| cal_done | input | 1 | Offset calibration finished |
| seek_done | input | 1 | Current seek finished |
| step_done | input | 1 | Return to track 0 finished |
| cpu_rst_hold | output | 1 | Holds the processor in reset |
| cal_start | output | 1 | Strobe: start offset calibration |
| seek_start | output | 1 | Strobe: start one short seek |
| seek_len | output | LEN_W | Seek distance in tracks, valid with `seek_start` |
| null_start | output | 1 | Strobe: begin null-current servo dwell |
| step_start | output | 1 | Strobe: step heads out to track 0 |
| drive_ready | output | 1 | Drive ready flag |
| seek_cmplt | output | 1 | Seek complete flag |

## Verification
A wrong state in this block shows up at the strobe outputs within a cycle or two. A skipped phase or a repeated phase breaks the strict strobe order, so the scoreboard catches it on the next strobe. A miscounted seek burst shows as the wrong number of seek strobes before the null strobe. A bad speed measurement or bad dwell count shows as a reset release or calibration start outside its window, measured in cycles from the index edge the bench drove. A sequencer that reacts to stray done pulses, or loses its flags, is caught by the flags and strobe counts in the quiet windows that follow those pulses.

// File: rtl/spinup_pkg.sv
package spinup_pkg;

    typedef enum logic [3:0] {
        ST_HOLD,
        ST_WAIT_OP,
        ST_SETTLE,
        ST_CAL_GO,
        ST_CAL_WAIT,
        ST_SEEK_GO,
        ST_SEEK_WAIT,
        ST_NULL_GO,
        ST_NULL_DWELL,
        ST_STEP_GO,
        ST_STEP_WAIT,
        ST_READY
    } seq_state_e;

endpackage

// File: rtl/index_period_meter.sv
// Measures clock cycles between falling edges of the active-low index and
// compares the result against the two spindle speed gates.
module index_period_meter #(
    parameter int unsigned CNT_W          = 32,
    parameter int unsigned LOW_PERIOD_MAX = 6_000_000,
    parameter int unsigned OP_PERIOD_MAX  = 4_000_000
) (
    input  logic clk,
    input  logic por,
    input  logic index_n,
    output logic above_low,
    output logic above_op
);

    localparam logic [CNT_W-1:0] CNT_SAT  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] LOW_LIM  = CNT_W'(LOW_PERIOD_MAX);
    localparam logic [CNT_W-1:0] OP_LIM   = CNT_W'(OP_PERIOD_MAX);

    typedef struct packed {
        logic             sync1;
        logic             sync2;
        logic             prev;
        logic             seen;
        logic             valid;
        logic [CNT_W-1:0] elapsed;
        logic [CNT_W-1:0] period;
    } meter_t;

    meter_t m_q, m_d;
    logic   fall_edge;

    always_comb begin
        m_d       = m_q;
        m_d.sync1 = index_n;
        m_d.sync2 = m_q.sync1;
        m_d.prev  = m_q.sync2;
        fall_edge = m_q.prev & ~m_q.sync2;
        if (fall_edge) begin
            m_d.seen    = 1'b1;
            m_d.elapsed = '0;
            if (m_q.seen) begin
                m_d.period = m_q.elapsed + CNT_W'(1);
                m_d.valid  = 1'b1;
            end
        end else if (m_q.elapsed != CNT_SAT) begin
            m_d.elapsed = m_q.elapsed + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            m_q.sync1   <= 1'b1;
            m_q.sync2   <= 1'b1;
            m_q.prev    <= 1'b1;
            m_q.seen    <= 1'b0;
            m_q.valid   <= 1'b0;
            m_q.elapsed <= '0;
            m_q.period  <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    // A stalled spindle is seen through the running count as well.
    assign above_low = m_q.valid && (m_q.period < LOW_LIM) && (m_q.elapsed < LOW_LIM);
    assign above_op  = m_q.valid && (m_q.period <= OP_LIM) && (m_q.elapsed < LOW_LIM);

endmodule

// File: rtl/dwell_timer.sv
// Shared down-counter for the settle and null-current dwells.
module dwell_timer #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             por,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] left_q, left_d;

    always_comb begin
        if (load) begin
            left_d = load_val;
        end else if (left_q != '0) begin
            left_d = left_q - CNT_W'(1);
        end else begin
            left_d = left_q;
        end
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            left_q <= '0;
        end else begin
            left_q <= left_d;
        end
    end

    assign expired = (left_q == '0) && !load;

endmodule

// File: rtl/spinup_sequencer.sv
module spinup_sequencer #(
    parameter int unsigned CNT_W          = 32,
    parameter int unsigned LOW_PERIOD_MAX = 6_000_000,
    parameter int unsigned OP_PERIOD_MAX  = 4_000_000,
    parameter int unsigned SETTLE_CYCLES  = 400_000_000,
    parameter int unsigned NULL_CYCLES    = 220_000_000,
    parameter int unsigned SEEK_COUNT     = 100,
    parameter int unsigned SEEK_LEN       = 5,
    parameter int unsigned LEN_W          = 4
) (
    input  logic             clk,
    input  logic             por,
    input  logic             index_n,
    input  logic             cal_done,
    input  logic             seek_done,
    input  logic             step_done,
    output logic             cpu_rst_hold,
    output logic             cal_start,
    output logic             seek_start,
    output logic [LEN_W-1:0] seek_len,
    output logic             null_start,
    output logic             step_start,
    output logic             drive_ready,
    output logic             seek_cmplt
);

    import spinup_pkg::*;

    localparam int unsigned SEEK_W = $clog2(SEEK_COUNT + 1);
    localparam logic [SEEK_W-1:0] SEEK_LAST = SEEK_W'(SEEK_COUNT - 1);
    localparam logic [CNT_W-1:0]  SETTLE_LD = CNT_W'(SETTLE_CYCLES);
    localparam logic [CNT_W-1:0]  NULL_LD   = CNT_W'(NULL_CYCLES);

    typedef struct packed {
        seq_state_e        state;
        logic [SEEK_W-1:0] seeks;
    } seq_t;

    seq_t              s_q, s_d;
    logic              spd_low_ok;
    logic              spd_op_ok;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;

    index_period_meter #(
        .CNT_W          (CNT_W),
        .LOW_PERIOD_MAX (LOW_PERIOD_MAX),
        .OP_PERIOD_MAX  (OP_PERIOD_MAX)
    ) u_meter (
        .clk       (clk),
        .por       (por),
        .index_n   (index_n),
        .above_low (spd_low_ok),
        .above_op  (spd_op_ok)
    );

    dwell_timer #(
        .CNT_W (CNT_W)
    ) u_dwell (
        .clk      (clk),
        .por      (por),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_comb begin
        s_d      = s_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (s_q.state)
            ST_HOLD: begin
                if (spd_low_ok) s_d.state = ST_WAIT_OP;
            end
            ST_WAIT_OP: begin
                if (spd_op_ok) begin
                    s_d.state = ST_SETTLE;
                    tmr_load  = 1'b1;
                    tmr_val   = SETTLE_LD;
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) s_d.state = ST_CAL_GO;
            end
            ST_CAL_GO: begin
                s_d.state = ST_CAL_WAIT;
            end
            ST_CAL_WAIT: begin
                if (cal_done) begin
                    s_d.state = ST_SEEK_GO;
                    s_d.seeks = '0;
                end
            end
            ST_SEEK_GO: begin
                s_d.state = ST_SEEK_WAIT;
            end
            ST_SEEK_WAIT: begin
                if (seek_done) begin
                    if (s_q.seeks == SEEK_LAST) begin
                        s_d.state = ST_NULL_GO;
                    end else begin
                        s_d.seeks = s_q.seeks + SEEK_W'(1);
                        s_d.state = ST_SEEK_GO;
                    end
                end
            end
            ST_NULL_GO: begin
                s_d.state = ST_NULL_DWELL;
                tmr_load  = 1'b1;
                tmr_val   = NULL_LD;
            end
            ST_NULL_DWELL: begin
                if (tmr_expired) s_d.state = ST_STEP_GO;
            end
            ST_STEP_GO: begin
                s_d.state = ST_STEP_WAIT;
            end
            ST_STEP_WAIT: begin
                if (step_done) s_d.state = ST_READY;
            end
            ST_READY: begin
                s_d.state = ST_READY;
            end
            default: begin
                s_d.state = ST_HOLD;
            end
        endcase
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            s_q.state <= ST_HOLD;
            s_q.seeks <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cpu_rst_hold = (s_q.state == ST_HOLD);
    assign cal_start    = (s_q.state == ST_CAL_GO);
    assign seek_start   = (s_q.state == ST_SEEK_GO);
    assign seek_len     = (s_q.state == ST_SEEK_GO) ? LEN_W'(SEEK_LEN) : '0;
    assign null_start   = (s_q.state == ST_NULL_GO);
    assign step_start   = (s_q.state == ST_STEP_GO);
    assign drive_ready  = (s_q.state == ST_READY);
    assign seek_cmplt   = (s_q.state == ST_READY);

endmodule

// File: rtl/spinup_sequencer_chk.sv
module spinup_sequencer_chk #(
    parameter int unsigned SEEK_COUNT = 100
) (
    input logic clk,
    input logic por,
    input logic cpu_rst_hold,
    input logic cal_start,
    input logic cal_done,
    input logic seek_start,
    input logic null_start,
    input logic step_start,
    input logic step_done,
    input logic drive_ready,
    input logic seek_cmplt
);

    localparam int unsigned CW = $clog2(SEEK_COUNT + 1) + 1;
    localparam logic [CW-1:0] CSAT = {CW{1'b1}};

    logic [CW-1:0] seek_tally;

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            seek_tally <= '0;
        end else if (seek_start && seek_tally != CSAT) begin
            seek_tally <= seek_tally + CW'(1);
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        por |=> (cpu_rst_hold && !drive_ready && !seek_cmplt
                 && !cal_start && !seek_start && !null_start && !step_start));

    assert_release_sticky_R2: assert property (@(posedge clk) disable iff (por)
        !cpu_rst_hold |=> !cpu_rst_hold);

    assert_cal_pulse_R4: assert property (@(posedge clk) disable iff (por)
        cal_start |=> !cal_start);

    assert_first_seek_after_done_R4: assert property (@(posedge clk) disable iff (por)
        (seek_start && seek_tally == '0) |-> $past(cal_done));

    assert_seek_total_R5: assert property (@(posedge clk) disable iff (por)
        null_start |-> (seek_tally == CW'(SEEK_COUNT)));

    assert_ready_after_step_R7: assert property (@(posedge clk) disable iff (por)
        $rose(drive_ready) |-> $past(step_done));

    assert_flags_hold_R8: assert property (@(posedge clk) disable iff (por)
        drive_ready |=> (drive_ready && seek_cmplt));

    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (por)
        $onehot0({cal_start, seek_start, null_start, step_start}));

    assert_seek_pulse_R10: assert property (@(posedge clk) disable iff (por)
        seek_start |=> !seek_start);

endmodule

bind spinup_sequencer spinup_sequencer_chk #(
    .SEEK_COUNT (SEEK_COUNT)
) u_chk (
    .clk          (clk),
    .por          (por),
    .cpu_rst_hold (cpu_rst_hold),
    .cal_start    (cal_start),
    .cal_done     (cal_done),
    .seek_start   (seek_start),
    .null_start   (null_start),
    .step_start   (step_start),
    .step_done    (step_done),
    .drive_ready  (drive_ready),
    .seek_cmplt   (seek_cmplt)
);

// File: tb/tb_spinup_sequencer.sv
`timescale 1ns/1ps
module tb_spinup_sequencer;

    localparam int LOW_MAX = 300;
    localparam int OP_MAX  = 200;
    localparam int SETTLE  = 50;
    localparam int NULLC   = 40;
    localparam int NSEEK   = 100;
    localparam int SLEN    = 5;

    logic       clk;
    logic       por;
    logic       index_n;
    logic       cal_done;
    logic       seek_done_auto, seek_done_frc;
    logic       step_done_auto, step_done_frc;
    logic       seek_done, step_done;
    logic       cpu_rst_hold, cal_start, seek_start, null_start, step_start;
    logic       drive_ready, seek_cmplt;
    logic [3:0] seek_len;

    assign seek_done = seek_done_auto | seek_done_frc;
    assign step_done = step_done_auto | step_done_frc;

    spinup_sequencer #(
        .CNT_W          (16),
        .LOW_PERIOD_MAX (LOW_MAX),
        .OP_PERIOD_MAX  (OP_MAX),
        .SETTLE_CYCLES  (SETTLE),
        .NULL_CYCLES    (NULLC),
        .SEEK_COUNT     (NSEEK),
        .SEEK_LEN       (SLEN),
        .LEN_W          (4)
    ) dut (
        .clk          (clk),
        .por          (por),
        .index_n      (index_n),
        .cal_done     (cal_done),
        .seek_done    (seek_done),
        .step_done    (step_done),
        .cpu_rst_hold (cpu_rst_hold),
        .cal_start    (cal_start),
        .seek_start   (seek_start),
        .seek_len     (seek_len),
        .null_start   (null_start),
        .step_start   (step_start),
        .drive_ready  (drive_ready),
        .seek_cmplt   (seek_cmplt)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    typedef enum int {EV_CAL, EV_SEEK, EV_NULL, EV_STEP} ev_e;
    ev_e exp_q[$];

    int  checks = 0;
    int  fails  = 0;
    int  cyc    = 0;
    int  idx_per = 400;
    int  cal_seen = 0, seek_seen = 0;
    bit  arm_op = 0;
    int  first_op = -1;
    bit  finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // spindle: falling edges of index_n exactly idx_per cycles apart
    initial begin
        index_n = 1'b1;
        tick(3);
        forever begin
            int p;
            p = idx_per;
            index_n = 1'b0;
            tick(4);
            index_n = 1'b1;
            tick(p - 4);
        end
    end

    // seek engine
    initial begin
        seek_done_auto = 1'b0;
        forever begin
            @(negedge clk);
            if (seek_start) begin
                tick(2);
                seek_done_auto = 1'b1;
                tick(1);
                seek_done_auto = 1'b0;
            end
        end
    end

    // step engine
    initial begin
        step_done_auto = 1'b0;
        forever begin
            @(negedge clk);
            if (step_start) begin
                tick(8);
                step_done_auto = 1'b1;
                tick(1);
                step_done_auto = 1'b0;
            end
        end
    end

    // monitor / scoreboard
    initial begin
        bit idx_prev = 1'b1, hold_prev = 1'b1, rdy_prev = 1'b0, have = 0, seen_fall = 0;
        int last_fall = 0, last_int = 0, null_cyc = 0, sd_cyc = -10;
        forever begin
            @(negedge clk);
            cyc++;
            if (idx_prev && !index_n) begin
                last_int = cyc - last_fall;
                last_fall = cyc;
                if (seen_fall) have = 1;
                seen_fall = 1;
                if (have && arm_op && first_op < 0 && last_int <= OP_MAX) first_op = cyc;
            end
            idx_prev = index_n;
            if (step_done && sd_cyc < 0) sd_cyc = cyc;
            if (cal_start || seek_start || null_start || step_start) begin
                ev_e got;
                got = cal_start ? EV_CAL : seek_start ? EV_SEEK : null_start ? EV_NULL : EV_STEP;
                if (cal_start) cal_seen++;
                if (seek_start) seek_seen++;
                if (exp_q.size() == 0) begin
                    chk(0, "R10", "unexpected strobe kind", int'(got), -1);
                end else begin
                    ev_e want;
                    want = exp_q.pop_front();
                    chk(got == want, "R5", "strobe order", int'(got), int'(want));
                end
                if (cal_start && first_op >= 0) begin
                    chk((cyc - first_op >= SETTLE) && (cyc - first_op <= SETTLE + 8),
                        "R3", "settle dwell before cal_start", cyc - first_op, SETTLE);
                    first_op = -2;
                end
                if (seek_start)
                    chk(seek_len == 4'(SLEN), "R5", "seek_len", int'(seek_len), SLEN);
                if (null_start) null_cyc = cyc;
                if (step_start) begin
                    chk((cyc - null_cyc >= NULLC) && (cyc - null_cyc <= NULLC + 3),
                        "R6", "null dwell", cyc - null_cyc, NULLC);
                    sd_cyc = -10;
                end
            end
            if (drive_ready && !rdy_prev) begin
                chk(cyc == sd_cyc + 1, "R7", "ready one cycle after step_done", cyc, sd_cyc + 1);
                chk(seek_cmplt == 1'b1, "R7", "seek_cmplt with ready", int'(seek_cmplt), 1);
                chk(cpu_rst_hold == 1'b0, "R7", "hold low at ready", int'(cpu_rst_hold), 0);
            end
            if (!cpu_rst_hold && hold_prev && !por) begin
                chk(have && last_int < LOW_MAX, "R2", "release needs fast period", last_int, LOW_MAX - 1);
                chk(cyc - last_fall <= 8, "R2", "release latency", cyc - last_fall, 8);
            end
            rdy_prev = drive_ready;
            hold_prev = cpu_rst_hold;
        end
    end

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int s0;
        por = 1'b1;
        cal_done = 1'b0;
        seek_done_frc = 1'b0;
        step_done_frc = 1'b0;
        tick(10);
        @(negedge clk);
        // R1: reset state
        chk(cpu_rst_hold == 1'b1, "R1", "hold in reset", int'(cpu_rst_hold), 1);
        chk(drive_ready == 1'b0 && seek_cmplt == 1'b0, "R1", "flags in reset",
            int'(drive_ready) + int'(seek_cmplt), 0);
        chk({cal_start, seek_start, null_start, step_start} == 4'b0, "R1", "strobes in reset",
            int'({cal_start, seek_start, null_start, step_start}), 0);
        tick(1);
        por = 1'b0;

        // R2: slow spindle keeps reset held
        tick(1300);
        chk(cpu_rst_hold == 1'b1, "R2", "hold at slow speed", int'(cpu_rst_hold), 1);

        idx_per = 250;
        for (int i = 0; i < 2000 && cpu_rst_hold; i++) tick(1);
        chk(cpu_rst_hold == 1'b0, "R2", "hold released above low speed", int'(cpu_rst_hold), 0);

        // R3/R10: below operating speed, stray done pulses
        tick(300);
        cal_done = 1'b1; seek_done_frc = 1'b1; step_done_frc = 1'b1;
        tick(1);
        cal_done = 1'b0; seek_done_frc = 1'b0; step_done_frc = 1'b0;
        tick(500);
        chk(cal_seen == 0, "R3", "no cal below operating speed", cal_seen, 0);
        chk(seek_seen == 0, "R10", "stray done ignored", seek_seen, 0);

        exp_q.push_back(EV_CAL);
        arm_op = 1;
        idx_per = 180;
        for (int i = 0; i < 3000 && cal_seen == 0; i++) tick(1);
        arm_op = 0;
        chk(cal_seen == 1, "R3", "cal_start issued", cal_seen, 1);

        // R4: waits for cal_done
        tick(30);
        chk(seek_seen == 0, "R4", "no seek before cal_done", seek_seen, 0);
        for (int i = 0; i < NSEEK; i++) exp_q.push_back(EV_SEEK);
        exp_q.push_back(EV_NULL);
        exp_q.push_back(EV_STEP);
        cal_done = 1'b1;
        tick(1);
        cal_done = 1'b0;

        for (int i = 0; i < 5000 && !drive_ready; i++) tick(1);
        tick(2);
        chk(seek_seen == NSEEK, "R5", "seek count", seek_seen, NSEEK);
        chk(exp_q.size() == 0, "R6", "all phases seen", exp_q.size(), 0);
        chk(drive_ready && seek_cmplt, "R7", "flags raised", int'(drive_ready) + int'(seek_cmplt), 2);

        // R8: flags persist, stray pulses ignored
        idx_per = 400;
        cal_done = 1'b1; seek_done_frc = 1'b1; step_done_frc = 1'b1;
        tick(2);
        cal_done = 1'b0; seek_done_frc = 1'b0; step_done_frc = 1'b0;
        tick(1000);
        @(negedge clk);
        chk(drive_ready && seek_cmplt, "R8", "flags persist", int'(drive_ready) + int'(seek_cmplt), 2);
        chk(cpu_rst_hold == 1'b0, "R8", "hold stays low", int'(cpu_rst_hold), 0);
        chk(seek_seen == NSEEK && cal_seen == 1, "R8", "no new phase", seek_seen, NSEEK);

        // R9: por from ready
        tick(1);
        por = 1'b1;
        @(negedge clk);
        chk(cpu_rst_hold == 1'b1, "R9", "hold after por at ready", int'(cpu_rst_hold), 1);
        chk(!drive_ready && !seek_cmplt, "R9", "flags cleared", int'(drive_ready) + int'(seek_cmplt), 0);
        tick(5);
        idx_per = 180;
        por = 1'b0;

        exp_q.push_back(EV_CAL);
        for (int i = 0; i < 6000 && cal_seen < 2; i++) tick(1);
        chk(cal_seen == 2, "R9", "second bring-up reaches cal", cal_seen, 2);
        for (int i = 0; i < NSEEK; i++) exp_q.push_back(EV_SEEK);
        cal_done = 1'b1;
        tick(1);
        cal_done = 1'b0;
        for (int i = 0; i < 3000 && seek_seen < NSEEK + 20; i++) tick(1);

        // R9: por in the middle of the seek burst
        por = 1'b1;
        @(negedge clk);
        chk(cpu_rst_hold == 1'b1, "R9", "hold after por mid-seek", int'(cpu_rst_hold), 1);
        chk(!drive_ready, "R9", "ready low mid-seek por", int'(drive_ready), 0);
        exp_q.delete();
        s0 = seek_seen;
        tick(20);
        chk(seek_seen == s0, "R9", "no strobes during por", seek_seen, s0);

        finished = 1;
        summary();
        $finish;
    end

endmodule